// File: doc/BRIEF.md
# Fixed-Latency Global Trigger Decision Unit

This is the central trigger block of a detector data-acquisition chain. It runs on the base clock, which is the accelerator RF divided by 32 (about 16 MHz). It takes one trigger bit per cycle from each of six sources: track, energy-sum, cluster-count, muon, forward-calorimeter and timing-counter. Each source reports an event after its own latency, and no source takes more than 29 cycles. A programmable delay line on each source moves its bit so that all six bits line up 29 cycles after the event.

A fixed six-stage decision pipeline then turns the aligned bits into one trigger. It evaluates four maskable conditions and divides the high-rate calibration condition by 100. It also picks a timing reference. The final trigger therefore appears exactly 35 cycles after the event, which is about 2.2 µs. The timing-counter line also drives an early level-0 pulse, with its own delay register, aimed at cycle 14.

Delays, the level-0 delay and the condition mask are set through a small register port, which also reads back two event counters. The in-flight rule works as follows. The `evt_i` strobe marks the cycle in which an event occurs, and the block treats that event as in flight for 35 cycles afterwards. A configuration write issued during that time is held, and it takes effect on the first idle cycle.

Top module: `gtu_top`

## Requirements
- R1: When a source bit is sampled L cycles after the edge that samples `evt_i`, and that source's delay register holds 29−L, the trigger decision uses the bit and `trig_o` is high for exactly the one cycle after edge 35 (counting the `evt_i` edge as 0).
- R2: Delay registers are 5 bits wide and readable at addresses 0..5, in source order. The source order is track=0, energy-sum=1, cluster=2, muon=3, forward=4, timing-counter=5, and the same index is the bit position in `src_i`. All registers reset to 0.
- R3: A write issued while an event is in flight (the `evt_i` cycle and the 35 cycles after it) does not change any register during that event. It takes effect on the first idle cycle, and the event in progress uses the old values.
- R4: The conditions are: C0 = track AND cluster; C1 = energy-sum AND cluster; C2 = track AND muon; C3 = forward AND energy-sum. The final trigger is the OR of the enabled conditions.
- R5: Register 7 holds the condition mask, with bit i=1 disabling Ci. Disabling one condition leaves the others able to trigger.
- R6: C3 is prescaled. Its first qualifying occurrence after reset passes, and after that exactly one in every 100 passes.
- R7: The prescale count advances only when C3 is true and enabled. Occurrences while C3 is masked are not counted.
- R8: The timing-counter bit has priority as the timing reference, and the energy-sum bit is the fallback. `tsrc_o` reads 2'b01 for timing-counter and 2'b10 for energy-sum, and reads 2'b00 whenever `trig_o` is low.
- R9: An event with neither timing bit aligned produces no trigger, even if a condition is true.
- R10: `l0_o` is high in the one cycle after edge 14 when the timing-counter bit arrives at latency L and register 6 holds 14−L. This happens whatever the final decision is.
- R11: Register 8 counts final triggers and register 9 counts C3 prescale passes. Both reset to 0.
- R12: After reset, `trig_o`, `l0_o` and `tsrc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base system clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event occurrence strobe (one cycle) |
| src_i | input | 6 | Per-source trigger bits, indexed as in R2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| trig_o | output | 1 | Final trigger, fixed latency |
| tsrc_o | output | 2 | Timing reference used by the trigger |
| l0_o | output | 1 | Early level-0 pulse |

## Verification
The decision path is exercised with two sets of per-source latencies, including latencies of 0 and 29, so that any misalignment moves the trigger off cycle 35 or loses a condition. Separate events are used to tell the two timing sources apart:
- one event fires the timing counter;
- one fires only the energy-sum;
- one fires neither, with a condition still true.

Masking one condition shows the redundant conditions still fire. Runs of 250 calibration events, then masked and unmasked runs, pin down both the 1-in-100 spacing and the rule that the prescale count advances only when the condition is true and enabled. A write that lands mid-event targets the timing-counter delay, so applying it early would visibly drop that event's trigger.

// File: rtl/gtu_pkg.sv
package gtu_pkg;

    localparam int NSRC  = 6;
    localparam int NCOND = 4;

    localparam int IX_TRK  = 0;
    localparam int IX_ESUM = 1;
    localparam int IX_CLU  = 2;
    localparam int IX_MU   = 3;
    localparam int IX_FWD  = 4;
    localparam int IX_TC   = 5;

    localparam int ADR_L0   = NSRC;
    localparam int ADR_MASK = NSRC + 1;
    localparam int ADR_TCNT = NSRC + 2;
    localparam int ADR_PCNT = NSRC + 3;

    localparam logic [NCOND-1:0] CALIB_CONDS = 4'b1000;

    typedef enum logic [1:0] {
        TS_NONE = 2'b00,
        TS_TC   = 2'b01,
        TS_CAL  = 2'b10
    } tsel_e;

    typedef struct packed {
        logic [NCOND-1:0] hit;
        tsel_e            tsel;
    } cand_t;

    typedef struct packed {
        logic  fire;
        tsel_e tsel;
    } stage_t;

    function automatic logic [NCOND-1:0] eval_conds(input logic [NSRC-1:0] a);
        logic [NCOND-1:0] c;
        c[0] = a[IX_TRK]  & a[IX_CLU];
        c[1] = a[IX_ESUM] & a[IX_CLU];
        c[2] = a[IX_TRK]  & a[IX_MU];
        c[3] = a[IX_FWD]  & a[IX_ESUM];
        return c;
    endfunction

    function automatic tsel_e pick_timing(input logic tc, input logic cal);
        if (tc)
            return TS_TC;
        else if (cal)
            return TS_CAL;
        else
            return TS_NONE;
    endfunction

endpackage

// File: rtl/gtu_align.sv
module gtu_align
    import gtu_pkg::*;
#(
    parameter int DLY_W = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSRC-1:0]             src_i,
    input  logic [NSRC-1:0][DLY_W-1:0]  dly,
    input  logic [DLY_W-1:0]            l0_dly,
    output logic [NSRC-1:0]             aligned,
    output logic                        l0_o
);
    localparam int DEPTH = 1 << DLY_W;

    for (genvar g = 0; g < NSRC; g++) begin : g_line
        logic [DEPTH-1:0] sh;

        always_ff @(posedge clk) begin
            if (rst)
                sh <= '0;
            else
                sh <= {sh[DEPTH-2:0], src_i[g]};
        end

        assign aligned[g] = sh[dly[g]];

        if (g == IX_TC) begin : g_l0
            assign l0_o = sh[l0_dly];
        end
    end

endmodule

// File: rtl/gtu_prescale.sv
module gtu_prescale #(
    parameter int N    = 100,
    parameter int PS_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit,
    output logic            pass,
    output logic [PS_W-1:0] fill
);
    logic [PS_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (hit)
            cnt <= (cnt == PS_W'(N - 1)) ? '0 : cnt + 1'b1;
    end

    assign pass = hit && (cnt == '0);
    assign fill = cnt;

endmodule

// File: rtl/gtu_decide.sv
module gtu_decide
    import gtu_pkg::*;
#(
    parameter int               DEC_CYC    = 6,
    parameter int               PRESCALE_N = 100,
    parameter int               CNT_W      = 16,
    parameter logic [NCOND-1:0] PS_SEL     = CALIB_CONDS,
    parameter int               PS_W       = (PRESCALE_N > 1) ? $clog2(PRESCALE_N) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSRC-1:0]             aligned,
    input  logic [NCOND-1:0]            mask,
    output logic                        trig_o,
    output logic [1:0]                  tsrc_o,
    output logic [CNT_W-1:0]            trig_cnt,
    output logic [CNT_W-1:0]            ps_cnt,
    output logic [NCOND-1:0][PS_W-1:0]  ps_fill
);
    localparam int PIPE_N = DEC_CYC - 1;

    cand_t            s1;
    logic [NCOND-1:0] gated;
    logic [NCOND-1:0] pass;
    logic             fire;
    stage_t           pipe [PIPE_N];

    // stage 1: condition evaluation, masking, timing reference choice
    always_ff @(posedge clk) begin
        if (rst)
            s1 <= '{hit: '0, tsel: TS_NONE};
        else
            s1 <= '{hit:  eval_conds(aligned) & ~mask,
                    tsel: pick_timing(aligned[IX_TC], aligned[IX_ESUM])};
    end

    // stage 2: prescale on calibration-class conditions
    for (genvar i = 0; i < NCOND; i++) begin : g_cond
        if (PS_SEL[i]) begin : g_ps
            gtu_prescale #(.N(PRESCALE_N), .PS_W(PS_W)) i_ps (
                .clk  (clk),
                .rst  (rst),
                .hit  (s1.hit[i]),
                .pass (pass[i]),
                .fill (ps_fill[i])
            );
            assign gated[i] = pass[i];
        end else begin : g_direct
            assign pass[i]    = 1'b0;
            assign ps_fill[i] = '0;
            assign gated[i]   = s1.hit[i];
        end
    end

    assign fire = (|gated) && (s1.tsel != TS_NONE);

    // stages 2..DEC_CYC: fixed-length delivery pipe
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < PIPE_N; k++)
                pipe[k] <= '{fire: 1'b0, tsel: TS_NONE};
        end else begin
            pipe[0] <= '{fire: fire, tsel: fire ? s1.tsel : TS_NONE};
            for (int k = 1; k < PIPE_N; k++)
                pipe[k] <= pipe[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_cnt <= '0;
            ps_cnt   <= '0;
        end else begin
            if (pipe[PIPE_N-2].fire)
                trig_cnt <= trig_cnt + 1'b1;
            if (|pass)
                ps_cnt <= ps_cnt + 1'b1;
        end
    end

    assign trig_o = pipe[PIPE_N-1].fire;
    assign tsrc_o = pipe[PIPE_N-1].tsel;

endmodule

// File: rtl/gtu_cfg.sv
module gtu_cfg
    import gtu_pkg::*;
#(
    parameter int DLY_W     = 5,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 16,
    parameter int TOTAL_LAT = 35
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        evt_i,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [CNT_W-1:0]            trig_cnt,
    input  logic [CNT_W-1:0]            ps_cnt,
    output logic [NSRC-1:0][DLY_W-1:0]  dly_o,
    output logic [DLY_W-1:0]            l0_dly_o,
    output logic [NCOND-1:0]            mask_o,
    output logic                        busy_o
);
    localparam int FC_W = $clog2(TOTAL_LAT + 1);

    logic [FC_W-1:0]   fcnt;
    logic              idle;
    logic              pend_v;
    logic [ADDR_W-1:0] pend_a;
    logic [DATA_W-1:0] pend_d;
    logic              app_v;
    logic [ADDR_W-1:0] app_a;
    logic [DATA_W-1:0] app_d;

    assign idle   = (fcnt == '0) && !evt_i;
    assign busy_o = !idle;

    assign app_v = idle && (pend_v || wr_en);
    assign app_a = pend_v ? pend_a : wr_addr;
    assign app_d = pend_v ? pend_d : wr_data;

    // in-flight window and pending write slot
    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt   <= '0;
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
        end else begin
            if (evt_i)
                fcnt <= FC_W'(TOTAL_LAT);
            else if (fcnt != '0)
                fcnt <= fcnt - 1'b1;

            if (!idle || pend_v) begin
                if (wr_en) begin
                    pend_v <= 1'b1;
                    pend_a <= wr_addr;
                    pend_d <= wr_data;
                end else if (idle) begin
                    pend_v <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_o    <= '0;
            l0_dly_o <= '0;
            mask_o   <= '0;
        end else if (app_v) begin
            for (int i = 0; i < NSRC; i++)
                if (app_a == ADDR_W'(i))
                    dly_o[i] <= app_d[DLY_W-1:0];
            if (app_a == ADDR_W'(ADR_L0))
                l0_dly_o <= app_d[DLY_W-1:0];
            if (app_a == ADDR_W'(ADR_MASK))
                mask_o <= app_d[NCOND-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSRC; i++)
            if (rd_addr == ADDR_W'(i))
                rd_data = DATA_W'(dly_o[i]);
        if (rd_addr == ADDR_W'(ADR_L0))
            rd_data = DATA_W'(l0_dly_o);
        if (rd_addr == ADDR_W'(ADR_MASK))
            rd_data = DATA_W'(mask_o);
        if (rd_addr == ADDR_W'(ADR_TCNT))
            rd_data = DATA_W'(trig_cnt);
        if (rd_addr == ADDR_W'(ADR_PCNT))
            rd_data = DATA_W'(ps_cnt);
    end

endmodule

// File: rtl/gtu_top.sv
module gtu_top
    import gtu_pkg::*;
#(
    parameter int DLY_W      = 5,
    parameter int ALIGN_CYC  = 29,
    parameter int DEC_CYC    = 6,
    parameter int PRESCALE_N = 100,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_i,
    input  logic [5:0]        src_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              trig_o,
    output logic [1:0]        tsrc_o,
    output logic              l0_o
);
    localparam int TOTAL_LAT = ALIGN_CYC + DEC_CYC;
    localparam int PS_W      = (PRESCALE_N > 1) ? $clog2(PRESCALE_N) : 1;

    logic [NSRC-1:0][DLY_W-1:0] dly;
    logic [DLY_W-1:0]           l0_dly;
    logic [NCOND-1:0]           mask;
    logic                       cfg_busy;
    logic [NSRC-1:0]            aligned;
    logic [CNT_W-1:0]           trig_cnt;
    logic [CNT_W-1:0]           ps_cnt;
    logic [NCOND-1:0][PS_W-1:0] ps_fill;

    gtu_cfg #(
        .DLY_W(DLY_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .TOTAL_LAT(TOTAL_LAT)
    ) i_cfg (
        .clk(clk), .rst(rst), .evt_i(evt_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_cnt(trig_cnt), .ps_cnt(ps_cnt),
        .dly_o(dly), .l0_dly_o(l0_dly), .mask_o(mask), .busy_o(cfg_busy)
    );

    gtu_align #(.DLY_W(DLY_W)) i_align (
        .clk(clk), .rst(rst), .src_i(src_i),
        .dly(dly), .l0_dly(l0_dly),
        .aligned(aligned), .l0_o(l0_o)
    );

    gtu_decide #(
        .DEC_CYC(DEC_CYC), .PRESCALE_N(PRESCALE_N), .CNT_W(CNT_W),
        .PS_SEL(CALIB_CONDS), .PS_W(PS_W)
    ) i_decide (
        .clk(clk), .rst(rst), .aligned(aligned), .mask(mask),
        .trig_o(trig_o), .tsrc_o(tsrc_o),
        .trig_cnt(trig_cnt), .ps_cnt(ps_cnt), .ps_fill(ps_fill)
    );

endmodule

// File: rtl/gtu_checker.sv
module gtu_checker
    import gtu_pkg::*;
#(
    parameter int DLY_W      = 5,
    parameter int PRESCALE_N = 100,
    parameter int CNT_W      = 16,
    parameter int PS_W       = 7
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        trig_o,
    input logic [1:0]                  tsrc_o,
    input logic [CNT_W-1:0]            trig_cnt,
    input logic                        cfg_busy,
    input logic [NSRC-1:0][DLY_W-1:0]  dly,
    input logic [DLY_W-1:0]            l0_dly,
    input logic [NCOND-1:0]            mask,
    input logic [NCOND-1:0][PS_W-1:0]  ps_fill
);

    assert_tsrc_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tsrc_o));

    assert_trig_has_timing_R9: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (tsrc_o != 2'b00));

    assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (trig_cnt == $past(trig_cnt) + 1'b1));

    assert_count_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !trig_o |-> $stable(trig_cnt));

    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_busy |=> ($stable(dly) && $stable(l0_dly) && $stable(mask)));

    for (genvar i = 0; i < NCOND; i++) begin : g_fill
        assert_prescale_range_R6: assert property (@(posedge clk) disable iff (rst)
            ps_fill[i] < PS_W'(PRESCALE_N));
    end

endmodule

bind gtu_top gtu_checker #(
    .DLY_W(DLY_W), .PRESCALE_N(PRESCALE_N), .CNT_W(CNT_W), .PS_W(PS_W)
) i_gtu_checker (
    .clk(clk), .rst(rst), .trig_o(trig_o), .tsrc_o(tsrc_o),
    .trig_cnt(trig_cnt), .cfg_busy(cfg_busy), .dly(dly),
    .l0_dly(l0_dly), .mask(mask), .ps_fill(ps_fill)
);

// File: tb/test_gtu_top.sv
module test_gtu_top;
    localparam int CLK_PERIOD = 10;
    localparam int EVT_CYCLES = 46;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_i = 1'b0;
    logic [5:0]  src_i = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        trig_o;
    logic [1:0]  tsrc_o;
    logic        l0_o;

    int checks = 0;
    int errors = 0;

    // bench model state
    int lat [6];
    logic [3:0] mask_m = '0;
    int ps_m = 0;
    int tcnt_m = 0;
    int pcnt_m = 0;

    gtu_top i_gtu_top (
        .clk(clk), .rst(rst), .evt_i(evt_i), .src_i(src_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_o(trig_o), .tsrc_o(tsrc_o), .l0_o(l0_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        @(negedge clk);
        rd_addr = 4'(a);
        #1;
        check(rd_data == 16'(exp), req, $sformatf("read addr %0d", a), int'(rd_data), exp);
    endtask

    task automatic set_lat(input int l0, l1, l2, l3, l4, l5);
        lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3; lat[4] = l4; lat[5] = l5;
        for (int i = 0; i < 6; i++) wr(i, 29 - lat[i]);
        wr(6, 14 - lat[5]);
    endtask

    task automatic model(input logic [5:0] f, output bit et, output int ets);
        logic [3:0] c;
        bit p3;
        c[0] = f[0] & f[2];
        c[1] = f[1] & f[2];
        c[2] = f[0] & f[3];
        c[3] = f[4] & f[1];
        c = c & ~mask_m;
        p3 = c[3] && (ps_m == 0);
        if (c[3]) ps_m = (ps_m == 99) ? 0 : ps_m + 1;
        if (p3) pcnt_m++;
        ets = f[5] ? 1 : (f[1] ? 2 : 0);
        et = ((|c[2:0]) || p3) && (ets != 0);
        if (!et) ets = 0;
        if (et) tcnt_m++;
    endtask

    // one event; optional mid-event write with read-back of the old value
    task automatic run_event(input logic [5:0] f, input string req,
                             input int wr_at = -1, input int wa = 0,
                             input int wd = 0, input int old_val = 0);
        bit et;
        int ets, n_tr, at_tr, ts_tr, n_l0, at_l0;
        model(f, et, ets);
        n_tr = 0; at_tr = -1; ts_tr = 0; n_l0 = 0; at_l0 = -1;
        if (wr_at >= 0) rd_addr = 4'(wa);
        for (int n = 0; n < EVT_CYCLES; n++) begin
            @(negedge clk);
            if (n > 0) begin
                if (trig_o) begin n_tr++; at_tr = n - 1; ts_tr = int'(tsrc_o); end
                if (l0_o) begin n_l0++; at_l0 = n - 1; end
                if (wr_at >= 0 && n == wr_at + 2)
                    check(rd_data == 16'(old_val), "R3", "register during event",
                          int'(rd_data), old_val);
            end
            evt_i = (n == 0);
            for (int i = 0; i < 6; i++) src_i[i] = f[i] && (n == lat[i]);
            wr_en = (n == wr_at);
            wr_addr = 4'(wa); wr_data = 16'(wd);
        end
        check((n_tr == (et ? 1 : 0)) && (!et || at_tr == 35),
              req, "trigger cycle", at_tr, et ? 35 : -1);
        check(ts_tr == ets, req, "timing source", ts_tr, ets);
        check((n_l0 == (f[5] ? 1 : 0)) && (!f[5] || at_l0 == 14),
              "R10", "level-0 cycle", at_l0, f[5] ? 14 : -1);
    endtask

    task automatic t_reset();
        check(trig_o == 1'b0 && l0_o == 1'b0, "R12", "outputs after reset",
              int'({trig_o, l0_o}), 0);
        check(tsrc_o == 2'b00, "R12", "tsrc after reset", int'(tsrc_o), 0);
        for (int a = 0; a < 10; a++) rd_chk(a, 0, (a < 8) ? "R2" : "R11");
    endtask

    task automatic t_program();
        set_lat(10, 20, 22, 29, 5, 8);
        for (int i = 0; i < 6; i++) rd_chk(i, 29 - lat[i], "R2");
        rd_chk(6, 6, "R10");
    endtask

    task automatic t_timing();
        run_event(6'b100101, "R1 R8 tc");        // track+cluster, tc
        run_event(6'b000110, "R8 fallback");     // esum+cluster, no tc
        run_event(6'b000101, "R9 no timing");    // track+cluster, none
        run_event(6'b101001, "R4 C2 tc");        // track+muon, tc
    endtask

    task automatic t_relatch();
        set_lat(0, 29, 3, 15, 12, 14);
        run_event(6'b101101, "R1 latency set 2");
        run_event(6'b001110, "R4 C1 set 2");
    endtask

    task automatic t_mask();
        wr(7, 4'b0001); mask_m = 4'b0001;
        rd_chk(7, 1, "R5");
        run_event(6'b100101, "R5 C0 masked");
        run_event(6'b101101, "R5 C2 still fires");
        wr(7, 0); mask_m = '0;
    endtask

    task automatic t_prescale();
        for (int k = 0; k < 250; k++) run_event(6'b010010, "R6 calib");
        rd_chk(9, pcnt_m, "R6");
        check(pcnt_m == 3, "R6", "model passes", pcnt_m, 3);
        wr(7, 4'b1000); mask_m = 4'b1000;
        for (int k = 0; k < 50; k++) run_event(6'b010010, "R7 masked calib");
        wr(7, 0); mask_m = '0;
        for (int k = 0; k < 51; k++) run_event(6'b010010, "R7 resumed");
        rd_chk(9, 4, "R7");
    endtask

    task automatic t_deferred();
        run_event(6'b100101, "R3 event uses old delay", 5, 5, 0, 29 - lat[5]);
        rd_chk(5, 0, "R3");
        wr(5, 29 - lat[5]);
        run_event(6'b100101, "R3 restored");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_timing();
        t_relatch();
        t_mask();
        t_prescale();
        t_deferred();
        rd_chk(8, tcnt_m, "R11");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule